// File: doc/BRIEF.md
# Reduced-Precision Fixed-Point Multiplier

This block multiplies two signed fixed-point operands held in a wide 64-bit format (sign, 15 integer bits, 48 fraction bits) while using a narrower 47-bit multiplier inside. Each operand is first cut down to a reduced format with 15 integer bits and 31 fraction bits. The low fraction bits are discarded with rounding. The product of the two reduced operands is rescaled to the reduced format and saturated. It is then widened back to the 64-bit format by appending zero fraction bits. Downstream logic therefore keeps working in the wide format, while each multiplier is roughly half the size.

The reduced format keeps well above 12 integer bits, so values do not overflow in normal use. It also keeps well above 24 fraction bits, which an iterative solver needs to converge. The block is a three-stage pipeline: round, multiply, then rescale and saturate. It accepts one operand pair on every clock. An overflow flag travels with each result and marks any saturation that took place on either operand or on the product.

Top module: `fxm_reduced_mul`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `out_ovf` and `out_result` are all zero.
- R2: `out_valid` is high exactly three clock edges after the edge that sampled `in_valid` high, and at no other time.
- R3: Each operand is reduced by dropping its 17 lowest bits (bits 16..0) and adding one when bit 16 is set (round half up). Bits 15..0 have no effect on the result.
- R4: An operand whose upper 47 bits are the largest positive reduced value and whose bit 16 is set saturates to that largest value. In that case `out_ovf` is set on its result.
- R5: The result equals the full product of the reduced operands (62 fraction bits), arithmetically shifted right by 31. This rounds toward minus infinity.
- R6: A shifted product above 2^46-1 or below -2^46 (in 47-bit units) clamps to that limit, and `out_ovf` is set. The positive limit widens to 64'h7FFF_FFFF_FFFE_0000 and the negative limit to 64'h8000_0000_0000_0000.
- R7: Bits 16..0 of `out_result` are always zero whenever `out_valid` is high.
- R8: `out_ovf` is low whenever `out_valid` is low, and it is low on results where no saturation occurred.
- R9: Pairs presented on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_a | input | 64 | Operand A, signed Q15.48 |
| in_b | input | 64 | Operand B, signed Q15.48 |
| out_valid | output | 1 | Result is present |
| out_result | output | 64 | Product, signed Q15.48 with zero low 17 bits |
| out_ovf | output | 1 | Saturation occurred for this result |

## Verification
A wrong rounding decision in the first stage shows up as a result that is off by exactly one step of 2^-31 times the other operand, three cycles after the input. A stuck or misaligned valid bit in any stage moves or drops `out_valid` against the fixed three-cycle window on the very next vector. A lost saturation flag is visible at the ports as an extreme result without `out_ovf`. Each scenario therefore feeds values placed right at the rounding bit, the floor boundary and both clamp limits, and compares every output cycle.

// File: rtl/fxm_pkg.sv
package fxm_pkg;
    localparam int WIDE_W_DEF    = 64;
    localparam int WIDE_FRAC_DEF = 48;
    localparam int RED_FRAC_DEF  = 31;
endpackage

// File: rtl/fxm_narrow.sv
module fxm_narrow #(
    parameter int WIDE_W = fxm_pkg::WIDE_W_DEF,
    parameter int DROP_W = 17,
    localparam int RED_W = WIDE_W - DROP_W
) (
    input  logic [WIDE_W-1:0] op,
    output logic [RED_W-1:0]  red,
    output logic              sat
);
    localparam logic [RED_W-1:0] RED_MAX = {1'b0, {(RED_W-1){1'b1}}};

    logic [RED_W-1:0] upper;
    logic             round_bit;

    always_comb begin
        upper     = op[WIDE_W-1:DROP_W];
        round_bit = op[DROP_W-1];
        sat       = round_bit && (upper == RED_MAX);
        if (sat) red = RED_MAX;
        else     red = upper + {{(RED_W-1){1'b0}}, round_bit};
    end
endmodule

// File: rtl/fxm_rescale.sv
module fxm_rescale #(
    parameter int RED_W    = 47,
    parameter int RED_FRAC = fxm_pkg::RED_FRAC_DEF,
    localparam int PROD_W  = 2 * RED_W
) (
    input  logic [PROD_W-1:0] prod,
    output logic [RED_W-1:0]  red,
    output logic              sat
);
    localparam int HI = PROD_W - 1;
    localparam int LO = RED_FRAC + RED_W - 1;
    localparam logic [RED_W-1:0] RED_MAX = {1'b0, {(RED_W-1){1'b1}}};
    localparam logic [RED_W-1:0] RED_MIN = {1'b1, {(RED_W-1){1'b0}}};

    logic [HI-LO:0] head;
    logic           fits;

    always_comb begin
        head = prod[HI:LO];
        fits = (head == '0) || (head == '1);
        sat  = !fits;
        if (fits)          red = prod[LO:RED_FRAC];
        else if (prod[HI]) red = RED_MIN;
        else               red = RED_MAX;
    end
endmodule

// File: rtl/fxm_reduced_mul.sv
module fxm_reduced_mul #(
    parameter int WIDE_W    = fxm_pkg::WIDE_W_DEF,
    parameter int WIDE_FRAC = fxm_pkg::WIDE_FRAC_DEF,
    parameter int RED_FRAC  = fxm_pkg::RED_FRAC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WIDE_W-1:0] in_a,
    input  logic [WIDE_W-1:0] in_b,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_result,
    output logic              out_ovf
);
    localparam int DROP_W = WIDE_FRAC - RED_FRAC;
    localparam int RED_W  = WIDE_W - DROP_W;
    localparam int PROD_W = 2 * RED_W;

    // stage 1: rounded operands
    logic [WIDE_W-1:0] ops     [2];
    logic [RED_W-1:0]  red_c   [2];
    logic [1:0]        sat_c;
    logic [RED_W-1:0]  s1_a, s1_b;
    logic              s1_v, s1_ovf;

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    for (genvar g = 0; g < 2; g++) begin : g_narrow
        fxm_narrow #(.WIDE_W(WIDE_W), .DROP_W(DROP_W)) u_narrow (
            .op (ops[g]),
            .red(red_c[g]),
            .sat(sat_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_ovf <= 1'b0;
            s1_a   <= '0;
            s1_b   <= '0;
        end else begin
            s1_v   <= in_valid;
            s1_ovf <= in_valid && (|sat_c);
            s1_a   <= red_c[0];
            s1_b   <= red_c[1];
        end
    end

    // stage 2: full product
    logic [PROD_W-1:0] s2_prod;
    logic              s2_v, s2_ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_ovf  <= 1'b0;
            s2_prod <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_ovf  <= s1_ovf;
            s2_prod <= PROD_W'($signed(s1_a) * $signed(s1_b));
        end
    end

    // stage 3: rescale, clamp, widen
    logic [RED_W-1:0] res_c;
    logic             res_sat;

    fxm_rescale #(.RED_W(RED_W), .RED_FRAC(RED_FRAC)) u_rescale (
        .prod(s2_prod),
        .red (res_c),
        .sat (res_sat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_ovf    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s2_v;
            out_ovf    <= s2_v && (s2_ovf || res_sat);
            out_result <= {res_c, {DROP_W{1'b0}}};
        end
    end
endmodule

// File: rtl/fxm_reduced_mul_chk.sv
module fxm_reduced_mul_chk #(
    parameter int WIDE_W    = fxm_pkg::WIDE_W_DEF,
    parameter int WIDE_FRAC = fxm_pkg::WIDE_FRAC_DEF,
    parameter int RED_FRAC  = fxm_pkg::RED_FRAC_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WIDE_W-1:0] in_a,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_result,
    input logic              out_ovf
);
    localparam int DROP_W = WIDE_FRAC - RED_FRAC;
    localparam int RED_W  = WIDE_W - DROP_W;
    localparam logic [RED_W-1:0] RED_MAX = {1'b0, {(RED_W-1){1'b1}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    logic a_sat_in;
    assign a_sat_in = in_valid && (in_a[WIDE_W-1:DROP_W] == RED_MAX) && in_a[DROP_W-1];

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R4
    op_sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(a_sat_in, 3)) |-> out_ovf);

    // R7
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[DROP_W-1:0] == '0));

    // R8
    ovf_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_ovf);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && !out_ovf && out_result == '0));
endmodule

bind fxm_reduced_mul fxm_reduced_mul_chk #(
    .WIDE_W(WIDE_W), .WIDE_FRAC(WIDE_FRAC), .RED_FRAC(RED_FRAC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
);

// File: tb/tb_fxm_reduced_mul.sv
`timescale 1ns/1ps
module tb_fxm_reduced_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic        out_valid, out_ovf;
    logic [63:0] out_result;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";
    bit checking = 1'b0;

    localparam logic [63:0] ONE = 64'h0001_0000_0000_0000;
    localparam logic signed [46:0] MAX47 = {1'b0, {46{1'b1}}};
    localparam logic signed [46:0] MIN47 = {1'b1, {46{1'b0}}};

    always #2 clk = ~clk;

    fxm_reduced_mul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
    );

    function automatic logic signed [46:0] narrow_m(input logic [63:0] x, inout logic ov);
        logic signed [46:0] t;
        t = x[63:17];
        if (x[16]) begin
            if (t == MAX47) ov = 1'b1;
            else t = t + 47'sd1;
        end
        return t;
    endfunction

    function automatic logic [64:0] model(input logic [63:0] a, input logic [63:0] b);
        logic ov;
        logic signed [46:0] ra, rb, r;
        logic signed [93:0] p;
        logic signed [93:0] s;
        ov = 1'b0;
        ra = narrow_m(a, ov);
        rb = narrow_m(b, ov);
        p  = 94'(ra) * 94'(rb);
        s  = p >>> 31;
        if (s > 94'(MAX47))      begin r = MAX47; ov = 1'b1; end
        else if (s < 94'(MIN47)) begin r = MIN47; ov = 1'b1; end
        else r = s[46:0];
        return {ov, r, 17'b0};
    endfunction

    // expected-result delay line: three edges from input to output (R2)
    logic        ev [3];
    logic [64:0] ex [3];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin ev[i] <= 1'b0; ex[i] <= '0; end
        end else begin
            ev[0] <= in_valid;
            ex[0] <= model(in_a, in_b);
            ev[1] <= ev[0]; ex[1] <= ex[0];
            ev[2] <= ev[1]; ex[2] <= ex[1];
        end
    end

    always @(negedge clk) begin
        if (checking && rst_n) begin
            vectors++;
            if (out_valid !== ev[2]) begin
                miscompares++;
                $display("FAIL %s (R2): out_valid=%0b expected %0b", cur_req, out_valid, ev[2]);
            end else if (ev[2]) begin
                if (out_result !== ex[2][63:0] || out_ovf !== ex[2][64]) begin
                    miscompares++;
                    $display("FAIL %s: result=%h ovf=%0b expected %h ovf=%0b",
                             cur_req, out_result, out_ovf, ex[2][63:0], ex[2][64]);
                end
            end else if (out_ovf !== 1'b0) begin
                miscompares++;
                $display("FAIL %s (R8): idle ovf=%0b expected 0", cur_req, out_ovf);
            end
        end
    end

    task automatic send(input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0; in_a = '0; in_b = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_ovf !== 1'b0 || out_result !== '0) begin
            miscompares++;
            $display("FAIL R1: v=%0b ovf=%0b res=%h expected 0 0 0", out_valid, out_ovf, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_ovf !== 1'b0 || out_result !== '0) begin
            miscompares++;
            $display("FAIL R1: after release v=%0b ovf=%0b res=%h expected 0 0 0",
                     out_valid, out_ovf, out_result);
        end
        checking = 1'b1;
    endtask

    task automatic t_exact;
        cur_req = "R5";
        send(ONE + (ONE >> 1), ONE << 1);        // 1.5 * 2.0
        send(-(ONE + (ONE >> 1)), ONE << 1);     // -1.5 * 2.0
        send(ONE >> 2, -(ONE >> 3));             // 0.25 * -0.125
        idle(4);
    endtask

    task automatic t_floor;
        cur_req = "R5";
        send(64'h1 << 17, ONE >> 1);             // 2^-31 * 0.5 floors to 0
        send(-(64'h1 << 17), ONE >> 1);          // floors to -2^-31
        idle(4);
    endtask

    task automatic t_round;
        cur_req = "R3";
        send(ONE | (64'h1 << 16), ONE);          // rounds up
        send(ONE | 64'h0000_FFFF, ONE);          // low bits ignored
        send(-ONE + (64'h1 << 16), ONE);         // negative half rounds up
        send(ONE - 64'h1, ONE);                  // carry through rounding
        idle(4);
    endtask

    task automatic t_opsat;
        cur_req = "R4";
        send(64'h7FFF_FFFF_FFFF_FFFF, ONE >> 1);
        send(ONE >> 1, 64'h7FFF_FFFF_FFFF_0000);
        idle(4);
    endtask

    task automatic t_prodsat;
        cur_req = "R6";
        send(ONE * 200, ONE * 200);
        send(-(ONE * 200), ONE * 200);
        send(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        idle(4);
    endtask

    task automatic t_stream;
        logic [63:0] a, b;
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 3 == 0) begin a = a >>> 8; b = {{9{b[63]}}, b[63:9]}; end
            in_valid = (i % 7 != 6);
            in_a = a; in_b = b;
        end
        @(negedge clk);
        in_valid = 1'b0; in_a = '0; in_b = '0;
        idle(4);
    endtask

    task automatic t_idle_ovf;
        cur_req = "R8";
        @(negedge clk);
        in_valid = 1'b0; in_a = ONE * 300; in_b = ONE * 300;   // invalid, must not flag
        idle(5);
        in_a = '0; in_b = '0;
        cur_req = "R7";
        send(64'h0003_1234_5678_9ABC, 64'hFFFE_DCBA_9876_5432);
        idle(4);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_exact();
        t_floor();
        t_round();
        t_opsat();
        t_prodsat();
        t_idle_ovf();
        cur_req = "R2";
        send(ONE, ONE);
        idle(5);
        t_stream();
        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule